// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a register-mapped serial master. Software writes frames of 4 to 16 bits into an eight-entry transmit queue. The block shifts each frame out most-significant bit first on `sclk`/`mosi`. At the same time it samples `miso`, and it places each received frame in an eight-entry receive queue that software drains through the same data port. The clock polarity, the clock phase and the frame length are set in a first control word. Enable, loopback and the three interrupt masks sit in a second control word. A status word and a masked interrupt word report the queue levels and the pending requests.

The bit rate comes from outside. A separate divider consumes the rate and prescale fields that this block holds and returns `bitTick`, a one-cycle pulse for each half bit period. Every tick moves `sclk` by one edge. All logic runs on a single clock.

Top module: `ssp_master`

## Requirements
- R1: Registers sit at these byte offsets: 0x00 mode word, 0x04 control word, 0x08 data port, 0x0C status, 0x10 prescale, 0x14 interrupt word.
  - Mode word: bits 15:8 are the rate field, bit 7 is phase, bit 6 is polarity, bits 3:0 are the frame length minus one, and bits 5:4 read 0.
  - Control word: bit 0 is the receive mask, bit 1 the transmit mask, bit 2 the overrun mask, bit 3 loopback, bit 4 enable, bits 6:5 are stored and read back, and the higher bits read 0.
  - After reset every register reads 0, except status, which reads 0x0003.
- R2: The transmit queue holds 8 frames. A data-port write while it is full is dropped.
- R3: Each frame is driven on `mosi` MSB first. The frame is length-field+1 bits long, and length fields 0 to 2 give 4 bits. `mosi` is 0 between frames.
- R4: Between frames, `sclk` sits at the polarity bit. During a frame each `bitTick` toggles `sclk`, so one frame takes 2×length edges.
  - With phase 0, data is sampled on the first edge of each bit and changed on the second.
  - With phase 1, data is changed on the first edge (the first bit is already present) and sampled on the second.
- R5: Each completed frame is written to the receive queue right-justified, with zeros above the frame. A data-port read returns the oldest frame and removes it. A read of an empty queue returns 0 and removes nothing.
- R6: With loopback set, the receive shifter takes `mosi` and `miso` is ignored.
- R7: A frame that completes while the receive queue holds 8 frames is discarded and sets the overrun flag. Any write to 0x14 clears the flag, but a new overrun in the same cycle wins.
- R8: Status bits: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. Busy means a frame is shifting or the transmit queue is non-empty.
- R9: The transmit request holds while the transmit queue holds 4 or fewer frames. The receive request holds while the receive queue holds 4 or more frames. The interrupt word reports each request and the overrun flag ANDed with its mask, in bits 1, 0 and 2. `irq` is the OR of those three bits.
- R10: While enable is 0 no frame starts, and a frame in progress is abandoned with `sclk` back at its idle level. Queued transmit frames are kept.
- R11: `clkRate` carries the rate field. `clkPrescale` carries the prescale register, whose bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRe | input | 1 | Register read strobe (pops receive data at 0x08) |
| regRdata | output | 16 | Register read data, combinational from address |
| bitTick | input | 1 | Half-bit enable from the external divider |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| irq | output | 1 | Masked interrupt request |
| clkRate | output | 8 | Rate field for the divider |
| clkPrescale | output | 8 | Even prescale value for the divider |

## Verification
The bench builds the block with its default queue depth of 8. With that depth, eight back-to-back frames fill the receive queue and a ninth frame reaches the overrun path in a few hundred cycles. The half-level request thresholds also fall at 4 entries, where short pushes cross them in both directions. The bench varies the tick spacing (every cycle, every 3rd, every 4th) and frame lengths of 16, 8 and 4 bits, including a length field below the legal minimum. Together with all four clock modes, this covers both sampling edges and the widest and narrowest shift counts.

// File: rtl/ssp_master_pkg.sv
package ssp_master_pkg;
  localparam int FRAME_W = 16;
  localparam int SIZE_W  = 4;

  typedef struct packed {
    logic              enable;
    logic              loopback;
    logic              cpol;
    logic              cpha;
    logic [SIZE_W-1:0] sizeM1;
  } sspCfg_t;

  typedef struct packed {
    logic               txPush;
    logic               rxPop;
    logic [FRAME_W-1:0] txData;
  } sspStrobe_t;

  typedef struct packed {
    logic               txEmpty;
    logic               txFull;
    logic               txLow;
    logic               rxEmpty;
    logic               rxFull;
    logic               rxHigh;
    logic               busy;
    logic               rxDrop;
    logic [FRAME_W-1:0] rxHead;
  } sspStat_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign pushOk = push && (count != CNT_W'(DEPTH));
  assign popOk  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: a push into a full queue leaves the level unchanged
  a_r2_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) && push && !pop |=> (count == CNT_W'(DEPTH)));

  // R5: a pop from an empty queue removes nothing
  a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) && pop && !push |=> (count == '0));
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_master_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int EDGE_W = $clog2(2 * FRAME_W),
  localparam int FB_W   = $clog2(FRAME_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  sspCfg_t    cfg,
  input  sspStrobe_t strb,
  input  logic       bitTick,
  input  logic       misoIn,
  output logic       sclk,
  output logic       mosi,
  output sspStat_t   stat
);
  logic [FRAME_W-1:0] txHead, rxHead;
  logic [CNT_W-1:0]   txCount, rxCount;
  logic               txEmpty, rxFull;

  logic               active, sclkPh, modeCpol, modeCpha;
  logic [EDGE_W-1:0]  edgeCnt, lastEdge;
  logic [FRAME_W-1:0] txSr, rxSr, rxNext;
  logic [FB_W-1:0]    frameBits;
  logic               loadNow, tickStep, frameDone, capEdge, chgEdge, rxIn;

  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CNT_W'(DEPTH));

  ssp_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(strb.txPush), .pop(loadNow),
    .din(strb.txData), .dout(txHead), .count(txCount)
  );

  ssp_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(frameDone && !rxFull), .pop(strb.rxPop),
    .din(rxNext), .dout(rxHead), .count(rxCount)
  );

  always_comb begin
    if (cfg.sizeM1 < SIZE_W'(3)) frameBits = FB_W'(4);
    else                         frameBits = FB_W'(cfg.sizeM1) + FB_W'(1);
  end

  assign loadNow   = !active && cfg.enable && !txEmpty;
  assign tickStep  = active && cfg.enable && bitTick;
  assign frameDone = tickStep && (edgeCnt == lastEdge);
  assign capEdge   = (edgeCnt[0] == modeCpha);
  assign chgEdge   = !capEdge && (edgeCnt != '0);
  assign rxIn      = cfg.loopback ? txSr[FRAME_W-1] : misoIn;
  assign rxNext    = capEdge ? {rxSr[FRAME_W-2:0], rxIn} : rxSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      sclkPh   <= 1'b0;
      modeCpol <= 1'b0;
      modeCpha <= 1'b0;
      edgeCnt  <= '0;
      lastEdge <= '0;
      txSr     <= '0;
      rxSr     <= '0;
    end else if (loadNow) begin
      active   <= 1'b1;
      sclkPh   <= 1'b0;
      modeCpol <= cfg.cpol;
      modeCpha <= cfg.cpha;
      edgeCnt  <= '0;
      lastEdge <= EDGE_W'({frameBits, 1'b0} - 1'b1);
      txSr     <= txHead << (FB_W'(FRAME_W) - frameBits);
      rxSr     <= '0;
    end else if (active && !cfg.enable) begin
      active <= 1'b0;
    end else if (tickStep) begin
      sclkPh  <= ~sclkPh;
      edgeCnt <= edgeCnt + 1'b1;
      rxSr    <= rxNext;
      if (chgEdge)   txSr   <= txSr << 1;
      if (frameDone) active <= 1'b0;
    end
  end

  assign sclk = active ? (modeCpol ^ sclkPh) : cfg.cpol;
  assign mosi = active & txSr[FRAME_W-1];

  assign stat.txEmpty = txEmpty;
  assign stat.txFull  = (txCount == CNT_W'(DEPTH));
  assign stat.txLow   = (txCount <= CNT_W'(DEPTH / 2));
  assign stat.rxEmpty = (rxCount == '0);
  assign stat.rxFull  = rxFull;
  assign stat.rxHigh  = (rxCount >= CNT_W'(DEPTH / 2));
  assign stat.busy    = active || !txEmpty;
  assign stat.rxDrop  = frameDone && rxFull;
  assign stat.rxHead  = rxHead;

  // R10: with the port disabled the shifter is idle one cycle later
  a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> !active);

  // R4: without a tick the serial clock does not move mid-frame
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    active && cfg.enable && !bitTick |=> $stable(sclk));

  // R3: the last edge of a frame ends it
  a_r3_frame_ends: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !active);
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_master_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [FRAME_W-1:0] regWdata,
  input  logic              regRe,
  output logic [FRAME_W-1:0] regRdata,
  input  sspStat_t          stat,
  output sspCfg_t           cfg,
  output sspStrobe_t        strb,
  output logic              irq,
  output logic [7:0]        clkRate,
  output logic [7:0]        clkPrescale
);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_PRE  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_INT  = ADDR_W'('h14);

  logic [7:0]        rateField;
  logic              phaseBit, polBit;
  logic [SIZE_W-1:0] sizeField;
  logic [6:0]        ctrlWord;
  logic [6:0]        preHi;
  logic              ovrFlag;
  logic [2:0]        pending;
  logic              clrWrite;

  assign clrWrite = regWe && (regAddr == OFS_INT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateField <= '0;
      phaseBit  <= 1'b0;
      polBit    <= 1'b0;
      sizeField <= '0;
      ctrlWord  <= '0;
      preHi     <= '0;
      ovrFlag   <= 1'b0;
    end else begin
      if (regWe && regAddr == OFS_MODE) begin
        rateField <= regWdata[15:8];
        phaseBit  <= regWdata[7];
        polBit    <= regWdata[6];
        sizeField <= regWdata[SIZE_W-1:0];
      end
      if (regWe && regAddr == OFS_CTRL) ctrlWord <= regWdata[6:0];
      if (regWe && regAddr == OFS_PRE)  preHi    <= regWdata[7:1];
      if (stat.rxDrop)   ovrFlag <= 1'b1;
      else if (clrWrite) ovrFlag <= 1'b0;
    end
  end

  assign cfg.enable   = ctrlWord[4];
  assign cfg.loopback = ctrlWord[3];
  assign cfg.cpol     = polBit;
  assign cfg.cpha     = phaseBit;
  assign cfg.sizeM1   = sizeField;

  assign strb.txPush = regWe && (regAddr == OFS_DATA);
  assign strb.rxPop  = regRe && (regAddr == OFS_DATA);
  assign strb.txData = regWdata;

  assign pending = {ovrFlag & ctrlWord[2], stat.txLow & ctrlWord[1], stat.rxHigh & ctrlWord[0]};
  assign irq     = |pending;

  assign clkRate     = rateField;
  assign clkPrescale = {preHi, 1'b0};

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_MODE: regRdata = {rateField, phaseBit, polBit, 2'b00, sizeField};
      OFS_CTRL: regRdata = {9'd0, ctrlWord};
      OFS_DATA: regRdata = stat.rxEmpty ? '0 : stat.rxHead;
      OFS_STAT: regRdata = {11'd0, stat.busy, stat.rxFull, !stat.rxEmpty, !stat.txFull, stat.txEmpty};
      OFS_PRE:  regRdata = {8'd0, clkPrescale};
      OFS_INT:  regRdata = {13'd0, pending};
      default:  regRdata = '0;
    endcase
  end

  // R7: a discarded frame raises the overrun flag
  a_r7_drop_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    stat.rxDrop |=> ovrFlag);

  // R7: only a write to the clear offset lowers the flag
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !clrWrite |=> ovrFlag);
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_master_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [FRAME_W-1:0] regWdata,
  input  logic               regRe,
  output logic [FRAME_W-1:0] regRdata,
  input  logic               bitTick,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               irq,
  output logic [7:0]         clkRate,
  output logic [7:0]         clkPrescale
);
  sspCfg_t    cfg;
  sspStrobe_t strb;
  sspStat_t   stat;

  ssp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRe(regRe), .regRdata(regRdata), .stat(stat), .cfg(cfg), .strb(strb),
    .irq(irq), .clkRate(clkRate), .clkPrescale(clkPrescale)
  );

  ssp_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .bitTick(bitTick),
    .misoIn(miso), .sclk(sclk), .mosi(mosi), .stat(stat)
  );
endmodule

// File: tb/ssp_master_bench.sv
`timescale 1ns/1ps
module ssp_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic        regRe = 1'b0;
  logic [15:0] regRdata;
  logic        bitTick = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, mosi, irq;
  logic [7:0]  clkRate, clkPrescale;

  always #2 clk = ~clk;

  ssp_master u_ssp_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRe(regRe), .regRdata(regRdata), .bitTick(bitTick), .miso(miso),
    .sclk(sclk), .mosi(mosi), .irq(irq), .clkRate(clkRate), .clkPrescale(clkPrescale)
  );

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int txq[$];
  int rxq[$];
  bit mEn, mLb, mPol, mPha, mRie, mTie, mOie, mOvr;
  int mCtrl, mSize, mRate, mPre;
  bit mAct, mPh, mLPol, mLPha;
  int mEdge, mBits, mWord, mShifts, mAcc;

  function automatic int mosiExp();
    int idx;
    if (!mAct) return 0;
    idx = mBits - 1 - mShifts;
    if (idx < 0) return 0;
    return (mWord >> idx) & 1;
  endfunction

  function automatic int irqExp();
    return ((rxq.size() >= 4 && mRie) || (txq.size() <= 4 && mTie) || (mOvr && mOie)) ? 1 : 0;
  endfunction

  function automatic int modelRead(int a);
    case (a)
      'h00: return (mRate << 8) | (int'(mPha) << 7) | (int'(mPol) << 6) | mSize;
      'h04: return mCtrl;
      'h08: return (rxq.size() > 0) ? rxq[0] : 0;
      'h0C: return (int'(mAct || txq.size() > 0) << 4) | (int'(rxq.size() == 8) << 3) |
                   (int'(rxq.size() > 0) << 2) | (int'(txq.size() < 8) << 1) | int'(txq.size() == 0);
      'h10: return mPre & 'hFE;
      'h14: return (int'(mOvr && mOie) << 2) | (int'(txq.size() <= 4 && mTie) << 1) |
                   int'(rxq.size() >= 4 && mRie);
      default: return 0;
    endcase
  endfunction

  int sTx, sRx, sIn;
  bit sAct, sEn, sDone, sCap;

  always @(posedge clk) begin
    if (!rstN) begin
      txq.delete(); rxq.delete();
      {mEn, mLb, mPol, mPha, mRie, mTie, mOie, mOvr} = '0;
      mCtrl = 0; mSize = 0; mRate = 0; mPre = 0;
      mAct = 0; mPh = 0; mLPol = 0; mLPha = 0;
      mEdge = 0; mBits = 4; mWord = 0; mShifts = 0; mAcc = 0;
    end else begin
      sTx = txq.size(); sRx = rxq.size(); sAct = mAct; sEn = mEn; sDone = 0;
      if (sAct) begin
        if (!sEn) mAct = 0;
        else if (bitTick) begin
          sIn  = mLb ? mosiExp() : int'(miso);
          sCap = ((mEdge % 2) == int'(mLPha));
          if (sCap) mAcc = ((mAcc << 1) | sIn) & 'hFFFF;
          else if (mEdge != 0) mShifts++;
          if (mEdge == 2 * mBits - 1) begin sDone = 1; mAct = 0; end
          mEdge++;
          mPh = !mPh;
        end
      end else if (sEn && sTx > 0) begin
        mWord = txq.pop_front();
        mBits = (mSize < 3) ? 4 : mSize + 1;
        mAct = 1; mEdge = 0; mShifts = 0; mAcc = 0; mPh = 0;
        mLPol = mPol; mLPha = mPha;
      end
      if (sDone && sRx < 8) rxq.push_back(mAcc);
      if (regRe && regAddr == 5'h08 && sRx > 0) void'(rxq.pop_front());
      if (regWe && regAddr == 5'h08 && sTx < 8) txq.push_back(int'(regWdata));
      if (sDone && sRx == 8) mOvr = 1;
      else if (regWe && regAddr == 5'h14) mOvr = 0;
      if (regWe && regAddr == 5'h00) begin
        mRate = regWdata[15:8]; mPha = regWdata[7]; mPol = regWdata[6]; mSize = regWdata[3:0];
      end
      if (regWe && regAddr == 5'h04) begin
        mCtrl = regWdata[6:0];
        mRie = regWdata[0]; mTie = regWdata[1]; mOie = regWdata[2];
        mLb = regWdata[3]; mEn = regWdata[4];
      end
      if (regWe && regAddr == 5'h10) mPre = regWdata[7:0];
    end
  end

  // per-clock comparison of the serial pins and interrupt
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R4 sclk", sclk, (mAct ? (mLPol ^ mPh) : mPol));
      chk("R3 mosi", mosi, mosiExp());
      chk("R9 irq", irq, irqExp());
      chk("R11 divider fields", {clkRate, clkPrescale}, {mRate[7:0], mPre[7:0] & 8'hFE});
    end
  end

  // bit tick and serial input stimulus
  int tickDiv = 1;
  int tickCnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    bitTick <= (tickCnt == 0);
    tickCnt = (tickCnt + 1) % tickDiv;
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso    <= lfsr[0];
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    regAddr = 5'(a); regWdata = 16'(d); regWe = 1'b1;
    @(posedge clk); #1 regWe = 1'b0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    regAddr = 5'(a); regRe = 1'b1;
    #1 chk(req, regRdata, modelRead(a));
    @(posedge clk); #1 regRe = 1'b0;
  endtask

  task automatic waitIdle();
    int g = 0;
    while ((mAct || txq.size() > 0) && g < 20000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1/R8: reset values of every register
    rd('h00, "R1 mode reset"); rd('h04, "R1 ctrl reset"); rd('h0C, "R8 status reset");
    rd('h10, "R1 prescale reset"); rd('h14, "R9 int reset"); rd('h08, "R5 empty read");

    // R1/R11: field readback, prescale bit 0 forced low
    wr('h00, 'h35F7); rd('h00, "R1 mode readback");
    wr('h00, 'h3507);
    wr('h10, 'h0B); rd('h10, "R11 prescale even");
    wr('h04, 'h60); rd('h04, "R1 ctrl readback");

    // R2/R10: disabled port queues frames but shifts nothing; ninth push dropped
    for (int k = 0; k < 9; k++) wr('h08, 'h40 + k * 7);
    rd('h0C, "R2 tx full status");
    repeat (20) @(negedge clk);
    rd('h0C, "R10 no frame while disabled");

    // R3/R5/R8: enable, tick every cycle, fill receive queue
    wr('h04, 'h14);
    waitIdle();
    rd('h0C, "R8 rx full status");
    rd('h14, "R9 int with rx full");
    // R7: one more frame overruns
    wr('h08, 'h3C);
    waitIdle();
    rd('h14, "R7 overrun pending");
    wr('h14, 0);
    rd('h14, "R7 overrun cleared");
    for (int k = 0; k < 9; k++) rd('h08, "R5 rx data pop");
    rd('h0C, "R8 drained status");

    // R3/R4: all clock modes, several frame lengths
    wr('h04, 'h10);
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 3; s++) begin
        int sz;
        sz = (s == 0) ? 15 : ((s == 1) ? 3 : 1);
        tickDiv = (s == 1) ? 1 : 3;
        wr('h00, 'h1200 | ((m & 1) << 6) | ((m >> 1) << 7) | sz);
        for (int k = 0; k < 3; k++) wr('h08, 'hB6D3 ^ (k * 'h1111) ^ (m << 4));
        waitIdle();
        for (int k = 0; k < 3; k++) rd('h08, "R3 R4 mode frame");
      end
    end

    // R6: loopback returns the transmitted frame regardless of miso
    tickDiv = 1;
    wr('h00, 'h0007);
    wr('h04, 'h18);
    wr('h08, 'hA5);
    waitIdle();
    @(negedge clk); regAddr = 5'h08; regRe = 1'b1;
    #1 chk("R6 loopback data", regRdata, 'hA5);
    @(posedge clk); #1 regRe = 1'b0;
    wr('h00, 'h00CB);
    wr('h08, 'h5A3);
    waitIdle();
    rd('h08, "R6 loopback 12-bit mode 3");

    // R10: abort a frame by disabling mid-shift
    tickDiv = 4;
    wr('h00, 'h000F);
    wr('h04, 'h10);
    wr('h08, 'h1234);
    repeat (12) @(negedge clk);
    wr('h04, 'h00);
    repeat (5) @(negedge clk);
    rd('h0C, "R10 aborted frame idle");
    rd('h08, "R10 aborted frame not stored");

    // R9: request thresholds and masks
    tickDiv = 1;
    wr('h00, 'h0007);
    wr('h04, 'h03);
    rd('h14, "R9 tx request masked on");
    for (int k = 0; k < 6; k++) wr('h08, 'h11 * (k + 1));
    rd('h14, "R9 tx request dropped");
    wr('h04, 'h13);
    waitIdle();
    rd('h14, "R9 rx request");
    for (int k = 0; k < 6; k++) rd('h08, "R5 final pop");
    rd('h14, "R9 final int");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule